// File: doc/BRIEF.md
# Timer Capture/Compare Channel Pair

This block holds two capture/compare channels that share one free-running up-counter. Each channel runs in one of three modes. In input-capture mode it latches the counter value when a chosen edge arrives on its pin. In output-compare mode it drives its pin with a set, clear or toggle action when the counter reaches a programmed value. In PWM use it adds a toggle on each counter wrap and can force the output high for 100% duty. Every channel has an 8-bit control/status register and a 16-bit capture/compare register. These are reached through a plain register port with one-cycle read and write strobes.

Each channel raises an event flag. The flag reaches the shared interrupt request when its enable bit is set. Software clears a flag in two steps: it reads the control register while the flag is 1, then writes 0 to the flag bit. If a new event arrives between the read and the write, the flag stays set, so no event is lost.

In buffered mode, channel 0 takes channel 1's compare register as a second compare value. The two registers are used in turn on alternate counter periods, and all actions appear on pin 0. Pin 1 is then released to general-purpose use.

The register and pin interfaces are control/status signals. They are single-cycle strobes with no valid/ready flow, and no back-pressure exists.

Top module: `tmr_ccp_pair`

## Requirements
- R1: After reset both control registers, both flags, `irq`, `pin_oe` and `pin_out` are 0. The control register bits, from bit 7 to bit 0, are: flag, interrupt enable, buffer select (channel 0 only; reads 0 on channel 1), compare select, edge select high, edge select low, toggle-on-wrap, force-high.
- R2: Register map on `reg_addr`:
  - 0: channel 0 control; 1 and 2: channel 0 compare high and low byte.
  - 3: channel 1 control; 4 and 5: channel 1 compare high and low byte.
  - 6 and 7: counter high and low byte.
  - Compare bytes read back as written.
- R3: A channel is in capture mode when both select bits are 0 and the edge pair (bits 3:2) is nonzero. 01 captures rising edges, 10 falling edges and 11 both. The pin passes through two synchronizer flops. Three clock edges after the pin changes, the counter value of that cycle sits in the channel register and the flag is set.
- R4: A channel is in compare mode when a select bit is 1 and the edge pair is nonzero. The pin output enable is then 1. At the clock edge where an enabled counter step sees the counter equal to the compare register, the flag sets and the pin takes the action: 01 toggle, 10 clear, 11 set.
- R5: A write of 0 to the flag bit clears it only if the control register was read with the flag at 1 and no other control write came in between. Writing 1 to the flag, or writing 0 without that read, leaves it unchanged.
- R6: An event that occurs after the qualifying read keeps the flag set through the following write of 0.
- R7: `irq` is 1 exactly when some channel has both its flag and its interrupt enable set.
- R8: With toggle-on-wrap set in compare mode, the pin toggles once each time the counter wraps from all-ones to 0.
- R9: With force-high set in compare mode, the pin is 1 from the next cycle on, whatever compare actions occur.
- R10: An edge pair of 00 disables the channel: no flag is set by pin edges or matches, and its output enable is 0.
- R11: With buffer select and a nonzero edge pair on channel 0:
  - channel 0 compares against its own register in the first counter period after entry, and against channel 1's register in the next, alternating at each wrap;
  - all actions drive pin 0;
  - `pin_oe[1]` is 0 and channel 1's flag is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter step enable (prescaler output) |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_rd | input | 1 | One-cycle read strobe (arms flag clearing) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| cap_in | input | 2 | Channel pin inputs, asynchronous |
| pin_out | output | 2 | Channel pin output levels |
| pin_oe | output | 2 | Channel pin output enables |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle:
- a flag can only fall after a write of 0 to its control register;
- an event always leaves the flag set on the next cycle;
- a write of 1 never clears a flag;
- force-high holds the pin high;
- pin 1 stays released in buffered mode and whenever its edge pair is 00.

Other behaviour needs directed scenarios: the exact synchronizer latency and the latched counter value, the edge-type selection, and each compare action at its exact match cycle. The same holds for the read-then-write handshake with an event in between, the wrap toggle and the period-by-period alternation of the buffered compare values.

// File: rtl/tmr_ccp_pkg.sv
package tmr_ccp_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int RW = 16;
  localparam int NCH = 2;

  // control register bit positions (software decodes this layout)
  localparam int B_FLAG = 7;
  localparam int B_IE   = 6;
  localparam int B_BUF  = 5;
  localparam int B_CSEL = 4;
  localparam int B_EHI  = 3;
  localparam int B_ELO  = 2;
  localparam int B_TOG  = 1;
  localparam int B_FHI  = 0;

  localparam logic [AW-1:0] A_CNT_HI = 3'd6;
  localparam logic [AW-1:0] A_CNT_LO = 3'd7;

  function automatic logic [AW-1:0] ctl_addr(input int ch);
    return AW'(3 * ch);
  endfunction

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/tmr_ccp_cnt.sv
module tmr_ccp_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = step && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_ccp_chan.sv
module tmr_ccp_chan
  import tmr_ccp_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter bit HAS_BUF = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_step,
  input  logic             cnt_wrap,
  input  logic             cap_pin,
  input  logic             force_off,
  input  logic [RW-1:0]    cmp_ref,
  input  logic             ctl_wr,
  input  logic             ctl_rd,
  input  logic             hi_wr,
  input  logic             lo_wr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    ctl_q,
  output logic [RW-1:0]    cmp_q,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             evt
);
  localparam logic [DW-2:0] WMASK = HAS_BUF ? 7'h7F : 7'h5F;

  logic [DW-2:0] bits;
  logic          flag, armed, lvl;
  logic          s1, s2, prev;
  edge_sel_e     esel;
  logic          enabled, cmp_mode, cap_act, cmp_act;
  logic          rise, fall, cap_hit, match;
  logic [RW-1:0] cnt_x;

  assign esel     = edge_sel_e'(bits[B_EHI:B_ELO]);
  assign enabled  = (esel != EDGE_OFF) && !force_off;
  assign cmp_mode = bits[B_CSEL] || bits[B_BUF];
  assign cap_act  = enabled && !cmp_mode;
  assign cmp_act  = enabled && cmp_mode;
  assign cnt_x    = RW'(cnt);

  assign rise = s2 && !prev;
  assign fall = !s2 && prev;
  always_comb begin
    unique case (esel)
      EDGE_RISE: cap_hit = cap_act && rise;
      EDGE_FALL: cap_hit = cap_act && fall;
      EDGE_ANY:  cap_hit = cap_act && (rise || fall);
      default:   cap_hit = 1'b0;
    endcase
  end
  assign match = cmp_act && cnt_step && (cmp_ref == cnt_x);
  assign evt   = cap_hit || match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {s1, s2, prev} <= '0;
      bits  <= '0;
      flag  <= 1'b0;
      armed <= 1'b0;
      cmp_q <= '0;
      lvl   <= 1'b0;
    end else begin
      s1   <= cap_pin;
      s2   <= s1;
      prev <= s2;
      if (ctl_wr) bits <= wdata[DW-2:0] & WMASK;
      // flag handshake: event wins over the clearing write
      if (evt) flag <= 1'b1;
      else if (ctl_wr && !wdata[B_FLAG] && armed) flag <= 1'b0;
      if (evt || ctl_wr) armed <= 1'b0;
      else if (ctl_rd && flag) armed <= 1'b1;
      if (cap_hit) cmp_q <= cnt_x;
      else begin
        if (hi_wr) cmp_q[RW-1:DW] <= wdata;
        if (lo_wr) cmp_q[DW-1:0]  <= wdata;
      end
      if (!cmp_act)          lvl <= 1'b0;
      else if (bits[B_FHI])  lvl <= 1'b1;
      else if (match) begin
        unique case (esel)
          EDGE_RISE: lvl <= !lvl;
          EDGE_FALL: lvl <= 1'b0;
          default:   lvl <= 1'b1;
        endcase
      end else if (cnt_wrap && bits[B_TOG]) lvl <= !lvl;
    end
  end

  assign ctl_q   = {flag, bits};
  assign pin_out = lvl;
  assign pin_oe  = cmp_act;
endmodule

// File: rtl/tmr_ccp_pair.sv
module tmr_ccp_pair
  import tmr_ccp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [1:0]    cap_in,
  output logic [1:0]    pin_out,
  output logic [1:0]    pin_oe,
  output logic          irq
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [DW-1:0]    ctl_q [NCH];
  logic [RW-1:0]    cmp_q [NCH];
  logic [RW-1:0]    cmp_ref [NCH];
  logic [NCH-1:0]   evt, irq_v;
  logic             buf_mode, buf_sel;
  logic [RW-1:0]    cnt_x;

  tmr_ccp_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(cnt_en), .cnt(cnt), .wrap(wrap)
  );

  assign buf_mode = ctl_q[0][B_BUF] && (ctl_q[0][B_EHI:B_ELO] != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n || !buf_mode) buf_sel <= 1'b0;
    else if (wrap)           buf_sel <= !buf_sel;
  end

  assign cmp_ref[0] = (buf_mode && buf_sel) ? cmp_q[1] : cmp_q[0];
  assign cmp_ref[1] = cmp_q[1];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [AW-1:0] BASE = ctl_addr(g);
    tmr_ccp_chan #(.CNT_W(CNT_W), .HAS_BUF(g == 0)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .cnt(cnt), .cnt_step(cnt_en), .cnt_wrap(wrap),
      .cap_pin(cap_in[g]),
      .force_off((g == 1) ? buf_mode : 1'b0),
      .cmp_ref(cmp_ref[g]),
      .ctl_wr(reg_wr && reg_addr == BASE),
      .ctl_rd(reg_rd && reg_addr == BASE),
      .hi_wr(reg_wr && reg_addr == BASE + 3'd1),
      .lo_wr(reg_wr && reg_addr == BASE + 3'd2),
      .wdata(reg_wdata),
      .ctl_q(ctl_q[g]), .cmp_q(cmp_q[g]),
      .pin_out(pin_out[g]), .pin_oe(pin_oe[g]), .evt(evt[g])
    );
    assign irq_v[g] = ctl_q[g][B_FLAG] && ctl_q[g][B_IE];
  end

  assign irq   = |irq_v;
  assign cnt_x = RW'(cnt);

  always_comb begin
    unique case (reg_addr)
      3'd0:     reg_rdata = ctl_q[0];
      3'd1:     reg_rdata = cmp_q[0][15:8];
      3'd2:     reg_rdata = cmp_q[0][7:0];
      3'd3:     reg_rdata = ctl_q[1];
      3'd4:     reg_rdata = cmp_q[1][15:8];
      3'd5:     reg_rdata = cmp_q[1][7:0];
      A_CNT_HI: reg_rdata = cnt_x[15:8];
      default:  reg_rdata = cnt_x[7:0];
    endcase
  end
endmodule

// File: rtl/tmr_ccp_pair_chk.sv
module tmr_ccp_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] ctl0,
  input logic [7:0] ctl1,
  input logic [1:0] evt,
  input logic       buf_mode,
  input logic [1:0] pin_out,
  input logic [1:0] pin_oe
);
  // R5: a flag only falls after a write of 0 to its control register
  a_r5_fall_needs_write0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl0[7]) |-> $past(reg_wr && reg_addr == 3'd0 && !reg_wdata[7]));

  // R5: writing 1 never clears a set flag
  a_r5_write1_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd3 && reg_wdata[7] && ctl1[7]) |=> ctl1[7]);

  // R6: any event leaves the flag set next cycle, whatever is written
  a_r6_event_sets0: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |=> ctl0[7]);
  a_r6_event_sets1: assert property (@(posedge clk) disable iff (!rst_n)
    evt[1] |=> ctl1[7]);

  // R9: force-high in compare mode drives the pin high
  a_r9_force_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl0[0] && ctl0[5:4] != 2'b00 && ctl0[3:2] != 2'b00) |=> pin_out[0]);

  // R10: disabled channel does not drive its pin
  a_r10_off_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl1[3:2] == 2'b00) |-> !pin_oe[1]);

  // R11: pin 1 released in buffered mode
  a_r11_pin1_released: assert property (@(posedge clk) disable iff (!rst_n)
    buf_mode |-> !pin_oe[1]);
endmodule

bind tmr_ccp_pair tmr_ccp_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .ctl0(ctl_q[0]), .ctl1(ctl_q[1]), .evt(evt),
  .buf_mode(buf_mode), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/tmr_ccp_pair_test.sv
module tmr_ccp_pair_test;
  localparam int CW = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [1:0] cap_in = '0, pin_out, pin_oe;
  logic       irq;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  tmr_ccp_pair #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cap_in(cap_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wr16(input int ch, input logic [15:0] v);
    wr(3'(3 * ch + 1), v[15:8]);
    wr(3'(3 * ch + 2), v[7:0]);
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] v);
    logic [7:0] h, l;
    rd(a, h); rd(a + 3'd1, l);
    v = {h, l};
  endtask

  task automatic run(input int n);
    @(negedge clk); cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(3'd0, d); check("R1 ctl0 reset", d, 8'h00);
    rd(3'd3, d); check("R1 ctl1 reset", d, 8'h00);
    check("R1 irq/oe/out reset", {irq, pin_oe, pin_out}, 5'b0);
  endtask

  task automatic t_map;
    logic [15:0] v; logic [7:0] d;
    wr16(0, 16'h1234); rd16(3'd1, v); check("R2 cmp0 readback", v, 16'h1234);
    wr16(1, 16'hA55A); rd16(3'd4, v); check("R2 cmp1 readback", v, 16'hA55A);
    wr(3'd3, 8'hFF); rd(3'd3, d);
    check("R1 ch1 buffer bit reads 0, flag write1 ignored", d, 8'h5F);
    wr(3'd3, 8'h00);
  endtask

  task automatic t_capture;
    logic [15:0] c, v; logic [7:0] d;
    run(37); rd16(A_CNT_HI_T, c);
    wr(3'd0, 8'h44);
    @(negedge clk); cap_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R3 no flag before sync delay", irq, 1'b0);
    @(negedge clk);
    check("R3/R7 flag+irq three edges after pin", irq, 1'b1);
    rd16(3'd1, v); check("R3 captured counter", v, c);
    run(11); rd16(A_CNT_HI_T, c);
    @(negedge clk); cap_in[0] = 1'b0; repeat (4) @(negedge clk);
    rd16(3'd1, v); check("R3 falling edge ignored when rising selected", v, c - 16'd11);
    wr(3'd0, 8'h44); rd(3'd0, d);
    check("R5 write0 without read keeps flag", d[7], 1'b1);
    rd(3'd0, d); wr(3'd0, 8'hC4); rd(3'd0, d);
    check("R5 write1 keeps flag", d[7], 1'b1);
    rd(3'd0, d); wr(3'd0, 8'h4C); rd(3'd0, d);
    check("R5 read then write0 clears", d[7], 1'b0);
    check("R7 irq drops with flag", irq, 1'b0);
    @(negedge clk); cap_in[0] = 1'b1; repeat (4) @(negedge clk);
    rd16(3'd1, v); check("R3 any-edge captures", v, c);
  endtask

  task automatic t_race;
    logic [7:0] d;
    rd(3'd0, d);
    wr(3'd0, 8'h4C);
    rd(3'd0, d); check("R5 setup flag clear", d[7], 1'b0);
    @(negedge clk); cap_in[0] = 1'b0; repeat (4) @(negedge clk);
    rd(3'd0, d);
    @(negedge clk); cap_in[0] = 1'b1; repeat (4) @(negedge clk);
    wr(3'd0, 8'h4C); rd(3'd0, d);
    check("R6 event after read blocks clear", d[7], 1'b1);
    rd(3'd0, d); wr(3'd0, 8'h0C); rd(3'd0, d);
    check("R6 later handshake clears", d[7], 1'b0);
  endtask

  task automatic t_compare;
    logic [15:0] c;
    wr(3'd0, 8'h14);
    check("R4 oe in compare mode", pin_oe[0], 1'b1);
    rd16(A_CNT_HI_T, c); wr16(0, (c + 16'd3) % 16'd1024);
    @(negedge clk); cnt_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 no action before match", pin_out[0], 1'b0);
    @(negedge clk); cnt_en = 1'b0;
    check("R4 toggle at match edge", pin_out[0], 1'b1);
    wr(3'd0, 8'h18); rd16(A_CNT_HI_T, c); wr16(0, (c + 16'd5) % 16'd1024);
    run(10); check("R4 clear action", pin_out[0], 1'b0);
    wr(3'd0, 8'h1C); rd16(A_CNT_HI_T, c); wr16(0, (c + 16'd5) % 16'd1024);
    run(10); check("R4 set action", pin_out[0], 1'b1);
  endtask

  task automatic t_wrap_max;
    logic [15:0] c;
    wr(3'd0, 8'h00); wr(3'd0, 8'h16); wr16(0, 16'hFFFF);
    check("R8 start low", pin_out[0], 1'b0);
    run(1024); check("R8 toggle on first wrap", pin_out[0], 1'b1);
    run(1024); check("R8 toggle on second wrap", pin_out[0], 1'b0);
    wr(3'd0, 8'h19); rd16(A_CNT_HI_T, c); wr16(0, (c + 16'd5) % 16'd1024);
    run(20); check("R9 force-high overrides clear", pin_out[0], 1'b1);
  endtask

  task automatic t_inactive_irq;
    logic [7:0] d;
    wr(3'd1 + 3'd2, 8'h10); wr16(1, 16'd7);
    run(1030); rd(3'd3, d);
    check("R10 no match flag when edges off", d[7], 1'b0);
    check("R10 no oe when edges off", pin_oe[1], 1'b0);
    wr(3'd3, 8'h00);
    @(negedge clk); cap_in[1] = 1'b1; repeat (4) @(negedge clk);
    rd(3'd3, d); check("R10 no capture flag when edges off", d[7], 1'b0);
    wr(3'd3, 8'h48);
    @(negedge clk); cap_in[1] = 1'b0; repeat (4) @(negedge clk);
    check("R3/R7 ch1 falling capture raises irq", irq, 1'b1);
    wr(3'd3, 8'h08);
    check("R7 irq gated by enable", irq, 1'b0);
    rd(3'd3, d); check("R7 flag still set", d[7], 1'b1);
    wr(3'd3, 8'h14); rd(3'd3, d);
    check("R5 ch1 cleared", d[7], 1'b0);
  endtask

  task automatic t_buffered;
    logic [15:0] c; logic [CW-1:0] cm; logic sel, pexp; logic [7:0] d;
    int bad = 0;
    rd(3'd0, d); wr(3'd0, 8'h34);
    wr16(0, 16'd100); wr16(1, 16'd600);
    rd16(A_CNT_HI_T, c); cm = CW'(c);
    sel = 1'b0; pexp = pin_out[0];
    @(negedge clk); cnt_en = 1'b1;
    for (int i = 0; i < 2100; i++) begin
      if (cm == (sel ? CW'(600) : CW'(100))) pexp = ~pexp;
      if (cm == '1) sel = ~sel;
      cm = cm + 1'b1;
      @(negedge clk);
      if (pin_out[0] !== pexp || pin_oe[1] !== 1'b0) bad++;
    end
    cnt_en = 1'b0;
    check("R11 alternating compare on pin0, pin1 released", 16'(bad), 16'd0);
    rd(3'd3, d); check("R11 ch1 flag never set", d[7], 1'b0);
    rd(3'd0, d); check("R11 ch0 flag set by buffered match", d[7], 1'b1);
  endtask

  localparam logic [2:0] A_CNT_HI_T = 3'd6;

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_capture();
    t_race();
    t_compare();
    t_wrap_max();
    t_inactive_irq();
    t_buffered();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule